// File: doc/BRIEF.md
# Per-Pixel Colour Source Merge

This block assembles one scan of RGB pixels from three framebuffer planes that share a pixel grid. The first is a one-byte-per-pixel indexed plane. The second is a four-byte-per-pixel direct-colour plane, and the third is a four-byte-per-pixel control plane. For every pixel it reads all three planes at the same pixel offset. The top byte of the control word is a tag that chooses the colour source for that one pixel. The source is either the 24-bit colour held in the direct plane or the palette entry selected by the indexed byte. Pixels of both kinds may sit next to each other on a line.

A frame is started with a one-cycle pulse, which samples the active width and height. The block then walks the frame in raster order and issues one read per cycle to each plane. Every plane uses a fixed line pitch of 1024 pixels, whatever the active width. All indexed bytes go to an external palette through a request/index port, and the matching colour returns one cycle later. The direct path is delayed to line up with the palette answer, so the output stream stays in raster order. Each output pixel carries a valid flag, a start-of-line marker and an end-of-line marker.

Top module: `pxsel_merge`

## Requirements
- R1: After reset, and until the first frame-start pulse, plane_rd, pal_req and pix_valid stay low.
- R2: The pixel in column x and row y is read at indexed-plane byte address y*1024+x. It is read at byte address 4*(y*1024+x) in both the direct plane and the control plane. Reads are issued one per cycle in raster order.
- R3: When bits 31:24 of a pixel's control word equal 0x03, pix_data is {8'h00, direct word bits 23:0}: red in 23:16, green in 15:8, blue in 7:0. The direct word's top byte and the control word's low 24 bits are ignored.
- R4: With any other tag value (for example 0x00, 0x02, 0x07, 0x83, 0xFF), pix_data is {8'h00, pal_rgb}. pal_rgb is the palette's answer for the pixel's indexed byte. Direct and palette pixels mix freely on one line.
- R5: pal_req rises with pal_index equal to a pixel's indexed byte exactly 2 cycles after that pixel's plane read is presented. The palette answer is taken 1 cycle after pal_req.
- R6: A pixel appears on pix_valid exactly 4 cycles after its plane read, and 5 cycles after the clock edge that samples frame_start. The pixel count is width*height.
- R7: pix_sol is high on the column-0 pixel of each line and pix_eol is high on the column width-1 pixel. A width of 1 raises both on every pixel. Both are low when pix_valid is low.
- R8: cfg_width and cfg_height are sampled only on frame_start. Changing them during a frame has no effect on that frame.
- R9: A width above 1024 is treated as 1024, and a height above 768 is treated as 768.
- R10: A frame with a sampled width or height of zero issues no reads and produces no pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that samples the size and restarts the walk at pixel (0,0) |
| cfg_width | input | 11 | Active pixels per line |
| cfg_height | input | 10 | Active lines per frame |
| plane_rd | output | 1 | Read strobe shared by all three planes |
| idx_addr | output | 20 | Indexed-plane byte address |
| idx_rdata | input | 8 | Indexed byte, one cycle after the read |
| dir_addr | output | 22 | Direct-plane byte address |
| dir_rdata | input | 32 | Direct-colour word, one cycle after the read |
| ctl_addr | output | 22 | Control-plane byte address |
| ctl_rdata | input | 32 | Control word, one cycle after the read |
| pal_req | output | 1 | Palette lookup request |
| pal_index | output | 8 | Palette entry requested |
| pal_rgb | input | 24 | Palette colour, one cycle after pal_req |
| pix_valid | output | 1 | Output pixel valid |
| pix_data | output | 32 | Output pixel {8'h00, R, G, B} |
| pix_sol | output | 1 | First pixel of a line |
| pix_eol | output | 1 | Last pixel of a line |

## Verification
The bench counts cycles from the first falling edge after frame_start is sampled. Pixel k must show its plane read at count k+1, its palette request at count k+3 and its output pixel at count k+5. At every falling edge the bench compares each of these ports with the value its own model predicts for that count. A pixel that comes out early or late therefore fails, not only one with a wrong value. The plane and palette models in the bench are registered with one cycle of latency, and each pixel's data is computed from the address it was read at.

// File: rtl/pxsel_pkg.sv
package pxsel_pkg;

  localparam logic [7:0] TAG_DIRECT = 8'h03;

  typedef struct packed {
    logic vld;
    logic sol;
    logic eol;
  } pxsel_mark_t;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pxsel_rgb_t;

  function automatic logic tag_is_direct(input logic [31:0] ctl_word);
    return ctl_word[31:24] == TAG_DIRECT;
  endfunction

  function automatic pxsel_rgb_t split_direct(input logic [31:0] dir_word);
    pxsel_rgb_t c;
    c.r = dir_word[23:16];
    c.g = dir_word[15:8];
    c.b = dir_word[7:0];
    return c;
  endfunction

endpackage

// File: rtl/pxsel_walker.sv
module pxsel_walker
  import pxsel_pkg::*;
#(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 768,
  parameter int STRIDE = 1024,
  parameter int WW     = $clog2(MAX_W + 1),
  parameter int HW     = $clog2(MAX_H + 1),
  parameter int XB     = $clog2(STRIDE),
  parameter int YB     = $clog2(MAX_H),
  parameter int IA_W   = XB + YB,
  parameter int DA_W   = IA_W + 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start,
  input  logic [WW-1:0]   cfg_width,
  input  logic [HW-1:0]   cfg_height,
  output pxsel_mark_t     mark,
  output logic [IA_W-1:0] idx_addr,
  output logic [DA_W-1:0] dir_addr,
  output logic [DA_W-1:0] ctl_addr
);

  localparam logic [WW-1:0] W_CAP = WW'(MAX_W);
  localparam logic [HW-1:0] H_CAP = HW'(MAX_H);

  logic            run;
  logic [WW-1:0]   cur_x, w_lat, w_eff;
  logic [YB-1:0]   cur_y;
  logic [HW-1:0]   h_lat, h_eff;
  logic            last_x, last_y;
  logic [IA_W-1:0] pix_off;

  assign w_eff   = (cfg_width  > W_CAP) ? W_CAP : cfg_width;
  assign h_eff   = (cfg_height > H_CAP) ? H_CAP : cfg_height;
  assign last_x  = (cur_x == w_lat - WW'(1));
  assign last_y  = (HW'(cur_y) == h_lat - HW'(1));
  assign pix_off = {cur_y, XB'(cur_x)};

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      cur_x    <= '0;
      cur_y    <= '0;
      w_lat    <= '0;
      h_lat    <= '0;
      mark     <= '0;
      idx_addr <= '0;
      dir_addr <= '0;
      ctl_addr <= '0;
    end else begin
      mark <= '0;
      if (frame_start) begin
        w_lat <= w_eff;
        h_lat <= h_eff;
        cur_x <= '0;
        cur_y <= '0;
        run   <= (w_eff != '0) && (h_eff != '0);
      end else if (run) begin
        mark.vld <= 1'b1;
        mark.sol <= (cur_x == '0);
        mark.eol <= last_x;
        idx_addr <= pix_off;
        dir_addr <= {pix_off, 2'b00};
        ctl_addr <= {pix_off, 2'b00};
        if (last_x) begin
          cur_x <= '0;
          if (last_y) run <= 1'b0;
          else        cur_y <= cur_y + YB'(1);
        end else begin
          cur_x <= cur_x + WW'(1);
        end
      end
    end
  end

endmodule

// File: rtl/pxsel_tag.sv
module pxsel_tag
  import pxsel_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  pxsel_mark_t      mark_in,
  input  logic [IDX_W-1:0] idx_rdata,
  input  logic [31:0]      dir_rdata,
  input  logic [31:0]      ctl_rdata,
  output pxsel_mark_t      mark_out,
  output logic [IDX_W-1:0] pal_index,
  output pxsel_rgb_t       dir_rgb,
  output logic             use_direct
);

  pxsel_mark_t s1_mark;
  logic        unused_bits;

  assign unused_bits = ^{dir_rdata[31:24], ctl_rdata[23:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_mark    <= '0;
      mark_out   <= '0;
      pal_index  <= '0;
      dir_rgb    <= '0;
      use_direct <= 1'b0;
    end else begin
      s1_mark  <= mark_in;
      mark_out <= s1_mark;
      if (s1_mark.vld) begin
        pal_index  <= idx_rdata;
        dir_rgb    <= split_direct(dir_rdata);
        use_direct <= tag_is_direct(ctl_rdata);
      end
    end
  end

endmodule

// File: rtl/pxsel_align.sv
module pxsel_align
  import pxsel_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  pxsel_mark_t mark_in,
  input  pxsel_rgb_t  dir_in,
  input  logic        dir_sel_in,
  input  logic [23:0] pal_rgb,
  output logic        pix_valid,
  output logic [31:0] pix_data,
  output logic        pix_sol,
  output logic        pix_eol
);

  pxsel_mark_t s3_mark;
  pxsel_rgb_t  s3_dir;
  logic        s3_sel;
  logic [23:0] merged;

  assign merged = s3_sel ? s3_dir : pal_rgb;

  always_ff @(posedge clk) begin
    if (rst) begin
      s3_mark   <= '0;
      s3_dir    <= '0;
      s3_sel    <= 1'b0;
      pix_valid <= 1'b0;
      pix_data  <= '0;
      pix_sol   <= 1'b0;
      pix_eol   <= 1'b0;
    end else begin
      s3_mark   <= mark_in;
      s3_dir    <= dir_in;
      s3_sel    <= dir_sel_in;
      pix_valid <= s3_mark.vld;
      pix_sol   <= s3_mark.vld & s3_mark.sol;
      pix_eol   <= s3_mark.vld & s3_mark.eol;
      pix_data  <= s3_mark.vld ? {8'h00, merged} : 32'h0;
    end
  end

endmodule

// File: rtl/pxsel_merge.sv
module pxsel_merge
  import pxsel_pkg::*;
#(
  parameter int MAX_W  = 1024,
  parameter int MAX_H  = 768,
  parameter int STRIDE = 1024,
  parameter int IDX_W  = 8,
  localparam int WW    = $clog2(MAX_W + 1),
  localparam int HW    = $clog2(MAX_H + 1),
  localparam int XB    = $clog2(STRIDE),
  localparam int YB    = $clog2(MAX_H),
  localparam int IA_W  = XB + YB,
  localparam int DA_W  = IA_W + 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [WW-1:0]    cfg_width,
  input  logic [HW-1:0]    cfg_height,
  output logic             plane_rd,
  output logic [IA_W-1:0]  idx_addr,
  input  logic [IDX_W-1:0] idx_rdata,
  output logic [DA_W-1:0]  dir_addr,
  input  logic [31:0]      dir_rdata,
  output logic [DA_W-1:0]  ctl_addr,
  input  logic [31:0]      ctl_rdata,
  output logic             pal_req,
  output logic [IDX_W-1:0] pal_index,
  input  logic [23:0]      pal_rgb,
  output logic             pix_valid,
  output logic [31:0]      pix_data,
  output logic             pix_sol,
  output logic             pix_eol
);

  pxsel_mark_t s0_mark, s2_mark;
  pxsel_rgb_t  s2_dir;
  logic        s2_sel;

  pxsel_walker #(
    .MAX_W(MAX_W), .MAX_H(MAX_H), .STRIDE(STRIDE),
    .WW(WW), .HW(HW), .XB(XB), .YB(YB), .IA_W(IA_W), .DA_W(DA_W)
  ) u_walk (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .cfg_width(cfg_width), .cfg_height(cfg_height),
    .mark(s0_mark), .idx_addr(idx_addr), .dir_addr(dir_addr), .ctl_addr(ctl_addr)
  );

  assign plane_rd = s0_mark.vld;

  pxsel_tag #(.IDX_W(IDX_W)) u_tag (
    .clk(clk), .rst(rst), .mark_in(s0_mark),
    .idx_rdata(idx_rdata), .dir_rdata(dir_rdata), .ctl_rdata(ctl_rdata),
    .mark_out(s2_mark), .pal_index(pal_index), .dir_rgb(s2_dir), .use_direct(s2_sel)
  );

  assign pal_req = s2_mark.vld;

  pxsel_align u_align (
    .clk(clk), .rst(rst), .mark_in(s2_mark), .dir_in(s2_dir), .dir_sel_in(s2_sel),
    .pal_rgb(pal_rgb), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_sol(pix_sol), .pix_eol(pix_eol)
  );

endmodule

// File: rtl/pxsel_merge_chk.sv
module pxsel_merge_chk #(
  parameter int IA_W = 20,
  parameter int DA_W = 22
) (
  input logic            clk,
  input logic            rst,
  input logic            plane_rd,
  input logic [IA_W-1:0] idx_addr,
  input logic [DA_W-1:0] dir_addr,
  input logic [DA_W-1:0] ctl_addr,
  input logic [31:0]     dir_rdata,
  input logic [31:0]     ctl_rdata,
  input logic            pal_req,
  input logic [23:0]     pal_rgb,
  input logic            pix_valid,
  input logic [31:0]     pix_data,
  input logic            pix_sol,
  input logic            pix_eol
);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!plane_rd && !pal_req && !pix_valid));

  // R2: the three plane addresses describe the same pixel
  p_plane_offsets_r2: assert property (@(posedge clk) disable iff (rst)
    plane_rd |-> (dir_addr == {idx_addr, 2'b00} && ctl_addr == dir_addr));

  p_direct_pass_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(ctl_rdata[31:24], 3) == 8'h03)
      |-> (pix_data == {8'h00, $past(dir_rdata[23:0], 3)}));

  p_palette_pass_r4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(ctl_rdata[31:24], 3) != 8'h03)
      |-> (pix_data == {8'h00, $past(pal_rgb, 1)}));

  p_req_after_read_r5: assert property (@(posedge clk) disable iff (rst)
    $past(plane_rd, 2) |-> pal_req);

  p_out_after_req_r6: assert property (@(posedge clk) disable iff (rst)
    $past(pal_req, 2) |-> pix_valid);

  p_marks_need_valid_r7: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> (!pix_sol && !pix_eol));

  p_sol_after_eol_r7: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(pix_eol)) |-> pix_sol);

  logic unused_chk;
  assign unused_chk = ^{dir_rdata[31:24], ctl_rdata[23:0]};

endmodule

bind pxsel_merge pxsel_merge_chk #(.IA_W(IA_W), .DA_W(DA_W)) u_chk (.*);

// File: tb/pxsel_merge_bench.sv
module pxsel_merge_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        frame_start = 1'b0;
  logic [10:0] cfg_width = '0;
  logic [9:0]  cfg_height = '0;
  logic        plane_rd;
  logic [19:0] idx_addr;
  logic [7:0]  idx_rdata = '0;
  logic [21:0] dir_addr;
  logic [31:0] dir_rdata = '0;
  logic [21:0] ctl_addr;
  logic [31:0] ctl_rdata = '0;
  logic        pal_req;
  logic [7:0]  pal_index;
  logic [23:0] pal_rgb = '0;
  logic        pix_valid;
  logic [31:0] pix_data;
  logic        pix_sol, pix_eol;

  int total = 0;
  int bad = 0;
  int mode = 0;
  bit ended = 0;

  always #2 clk = ~clk;

  pxsel_merge u_pxsel_merge (.*);

  function automatic logic [7:0] f_idx(int p);
    return 8'((p + (p >> 10) * 3) & 255);
  endfunction

  function automatic logic [31:0] f_dir(int p);
    return {8'hC3, 24'((p * 37) ^ 24'h5A5A5A)};
  endfunction

  function automatic logic [7:0] f_tag(int p, int m);
    logic [7:0] pal_tags [4] = '{8'h00, 8'h02, 8'h07, 8'hFF};
    logic [7:0] mix_tags [5] = '{8'h00, 8'h83, 8'h02, 8'hFF, 8'h07};
    if (m == 0) return pal_tags[p % 4];
    if (m == 1) return 8'h03;
    return (p % 3 == 0) ? 8'h03 : mix_tags[p % 5];
  endfunction

  function automatic logic [23:0] f_pal(logic [7:0] i);
    return {i ^ 8'h11, ~i, i + 8'h40};
  endfunction

  // Registered plane and palette models, one cycle of latency each
  always @(posedge clk) begin
    if (plane_rd) begin
      idx_rdata <= f_idx(int'(idx_addr));
      dir_rdata <= f_dir(int'(dir_addr >> 2));
      ctl_rdata <= {f_tag(int'(ctl_addr >> 2), mode), 24'(int'(ctl_addr) ^ 24'hF0F0F0)};
    end
    if (pal_req) pal_rgb <= f_pal(pal_index);
  end

  task automatic check(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int pix_at(int k, int we);
    return (k / we) * 1024 + (k % we);
  endfunction

  // One frame: every port compared cycle by cycle against the model
  task automatic run_frame(int w, int h, int m, bit chg, string data_req, string cnt_req);
    int we = (w > 1024) ? 1024 : w;
    int he = (h > 768) ? 768 : h;
    int n = we * he;
    int e_rd = 0, e_pal = 0, e_vld = 0, e_dat = 0, e_mark = 0, outs = 0;
    mode = m;
    @(negedge clk);
    cfg_width = 11'(w);
    cfg_height = 10'(h);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int c = 0; c <= n + 10; c++) begin
      bit xr = (c >= 1) && (c - 1 < n);
      bit xp = (c >= 3) && (c - 3 < n);
      bit xv = (c >= 5) && (c - 5 < n);
      if (chg && c == 2) begin
        cfg_width = 11'd3;
        cfg_height = 10'd9;
      end
      if (plane_rd !== xr) e_rd++;
      else if (xr) begin
        int p = pix_at(c - 1, we);
        if (idx_addr !== 20'(p) || dir_addr !== 22'(p * 4) || ctl_addr !== 22'(p * 4)) e_rd++;
      end
      if (pal_req !== xp) e_pal++;
      else if (xp && pal_index !== f_idx(pix_at(c - 3, we))) e_pal++;
      if (pix_valid !== xv) e_vld++;
      if (pix_valid === 1'b1) outs++;
      if (xv) begin
        int k = c - 5;
        int p = pix_at(k, we);
        logic [31:0] exp_d = (f_tag(p, m) == 8'h03) ? {8'h00, f_dir(p)[23:0]}
                                                    : {8'h00, f_pal(f_idx(p))};
        if (pix_data !== exp_d) e_dat++;
        if (pix_sol !== (k % we == 0) || pix_eol !== (k % we == we - 1)) e_mark++;
      end else if (pix_sol !== 1'b0 || pix_eol !== 1'b0) e_mark++;
      @(negedge clk);
    end
    check(e_rd == 0, "R2 plane read addresses/order", e_rd, 0);
    check(e_pal == 0, "R5 palette request timing/index", e_pal, 0);
    check(e_vld == 0, "R6 output cycle", e_vld, 0);
    check(e_dat == 0, data_req, e_dat, 0);
    check(e_mark == 0, "R7 line markers", e_mark, 0);
    check(outs == n, cnt_req, outs, n);
  endtask

  task automatic t_reset();
    int errs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (plane_rd !== 1'b0 || pal_req !== 1'b0 || pix_valid !== 1'b0) errs++;
    end
    check(errs == 0, "R1 idle after reset", errs, 0);
  endtask

  task automatic t_palette_only();  run_frame(16, 3, 0, 0, "R4 palette colour", "R6 pixel count"); endtask
  task automatic t_direct_only();   run_frame(16, 3, 1, 0, "R3 direct colour", "R6 pixel count"); endtask
  task automatic t_mixed_line();    run_frame(37, 4, 2, 0, "R3/R4 mixed line colour", "R6 pixel count"); endtask
  task automatic t_single_column(); run_frame(1, 5, 2, 0, "R7 width one data", "R7 width one count"); endtask
  task automatic t_cfg_change();    run_frame(20, 2, 2, 1, "R8 data after cfg change", "R8 count after cfg change"); endtask
  task automatic t_clamp_width();   run_frame(2000, 1, 2, 0, "R9 wide data", "R9 width clamp count"); endtask
  task automatic t_clamp_height();  run_frame(1, 1000, 0, 0, "R9 tall data", "R9 height clamp count"); endtask
  task automatic t_zero_width();    run_frame(0, 5, 0, 0, "R10 zero width data", "R10 zero width count"); endtask
  task automatic t_zero_height();   run_frame(4, 0, 0, 0, "R10 zero height data", "R10 zero height count"); endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_palette_only();
    t_direct_only();
    t_mixed_line();
    t_single_column();
    t_cfg_change();
    t_clamp_width();
    t_clamp_height();
    t_zero_width();
    t_zero_height();
    if (!ended) begin
      ended = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule